// File: doc/BRIEF.md
# Supply Monitor Reset and Stop Controller

This block is the digital side of a supply monitor. Three comparator results arrive from the analog domain, each asynchronous to the block clock: the supply is below the power-on rearm level, below the low detect threshold, or below the alternate threshold. The block resynchronizes them and drives the system reset. It holds a record of what caused the latest reset, raises a sticky warning when detection is enabled but configured not to reset, and grants the stop mode that is actually entered.

Four configuration bits set its behaviour: detection enable, detection kept alive in stop, reset on detection, and threshold select. A power-on event returns them to their defaults. Reset always leaves synchronously, and only after the qualifying "above threshold" comparator has stayed clear for `HOLD_CYCLES` consecutive synchronized cycles.

Top module: `supply_guard`

## Requirements
- R1: While `coldRstN` is low, `sysRst` is 1, `rstStatus` is 2'b11, `cfgBits` is 4'b0101, and `warnFlag` and `stopActive` are 0. Config bits are [0] detect enable, [1] detect-in-stop enable, [2] reset enable and [3] alternate threshold select. Status bits are [1] power-on cause and [0] low-voltage cause.
- R2: A synchronized `belowRearm` asserts `sysRst` from any state. It sets `rstStatus` to 2'b11, restores `cfgBits` to 4'b0101 and clears `warnFlag`.
- R3: A power-on reset is released only after `belowRearm` is low and `belowLow` is low for `HOLD_CYCLES` consecutive synchronized cycles. Clearing the rearm comparator alone never releases it.
- R4: When detection is active, reset is enabled and the selected comparator reports below, `sysRst` asserts. `rstStatus` then reads 2'b01 and `cfgBits` keeps its value.
- R5: `cfgBits[3]`=0 selects `belowLow` and `cfgBits[3]`=1 selects `belowAlt`. The comparator that is not selected has no effect on detection or on release.
- R6: A low-voltage reset is released only after the selected comparator has read "above" for `HOLD_CYCLES` consecutive synchronized cycles. A single "below" cycle restarts the count.
- R7: With `cfgBits[0]`=0, no low-voltage condition asserts reset or sets `warnFlag`, and `lvdActive` is 0.
- R8: With detection active and `cfgBits[2]`=0, a low-voltage condition sets `warnFlag` and does not assert reset. The flag stays set after the supply recovers. A 1 on `warnClr` clears it.
- R9: `lvdActive` is 1 when `cfgBits[0]` is set and either the block is not stopped or `cfgBits[1]` is set. While stopped with `cfgBits[1]`=0, a low supply has no effect.
- R10: A stop request with `stopKind`=1 (stop2) is granted as stop2 (`stopIs2`=1) unless `cfgBits[0]` and `cfgBits[1]` are both set, in which case it is entered as stop3 (`stopIs2`=0). `stopKind`=0 always gives stop3.
- R11: `stopReq` enters stop only while out of reset. `wakeReq` leaves stop. Any reset event clears `stopActive`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| coldRstN | input | 1 | Asynchronous initial reset of the block's flops, active low |
| belowRearm | input | 1 | Comparator: supply below power-on rearm level (async) |
| belowLow | input | 1 | Comparator: supply below low detect threshold (async) |
| belowAlt | input | 1 | Comparator: supply below alternate threshold (async) |
| cfgWrEn | input | 1 | Write strobe for configuration bits |
| cfgWrData | input | 4 | Configuration value to write |
| warnClr | input | 1 | Write-1 clear of the warning flag |
| stopReq | input | 1 | Request to enter stop |
| stopKind | input | 1 | Requested stop: 1 = stop2, 0 = stop3 |
| wakeReq | input | 1 | Wake-up event, leaves stop |
| sysRst | output | 1 | System reset, active high |
| rstStatus | output | 2 | Reset cause: [1] power-on, [0] low-voltage |
| cfgBits | output | 4 | Current configuration bits |
| warnFlag | output | 1 | Sticky low-voltage warning |
| lvdActive | output | 1 | Detection currently armed |
| stopActive | output | 1 | Block is in stop |
| stopIs2 | output | 1 | Granted stop is stop2 (else stop3) |

## Verification
A comparator edge driven on one cycle passes two synchronizer flops and the state register, so `sysRst`, `rstStatus` and `warnFlag` respond after the third rising edge. A release falls due `HOLD_CYCLES + 2` edges after the comparator clears. Configuration writes, `warnClr`, `stopReq` and `wakeReq` take effect after one edge. The bench drives inputs on falling edges and counts edges from that point. For each timed result it checks the value one edge before the due edge, to show the result has not moved yet, and then the value on the due edge.

// File: rtl/guard_pkg.sv
package guard_pkg;

  typedef struct packed {
    logic altSel;
    logic rstEn;
    logic stopDetEn;
    logic detEn;
  } guardCfg_t;

  localparam guardCfg_t CFG_DEFAULT = '{altSel: 1'b0, rstEn: 1'b1, stopDetEn: 1'b0, detEn: 1'b1};

  typedef enum logic [1:0] {
    ST_RUN      = 2'd0,
    ST_POR_HOLD = 2'd1,
    ST_LVD_HOLD = 2'd2
  } guardState_e;

  typedef struct packed {
    logic porEvent;
    logic lvdEvent;
    logic warnSet;
    logic stopEnter;
    logic stopExit;
    logic cntStep;
  } guardStrobes_t;

endpackage

// File: rtl/guard_sync.sv
module guard_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] pipe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pipe <= '1;
    else       pipe <= {pipe[STAGES-2:0], din};
  end

  assign dout = pipe[STAGES-1];
endmodule

// File: rtl/guard_datapath.sv
module guard_datapath
  import guard_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int HOLD_CYCLES = 8
) (
  input  logic          clk,
  input  logic          coldRstN,
  input  logic          belowRearm,
  input  logic          belowLow,
  input  logic          belowAlt,
  input  logic          cfgWrEn,
  input  logic [3:0]    cfgWrData,
  input  logic          warnClr,
  input  logic          stopKind,
  input  guardStrobes_t strobes,
  output logic          syncRearm,
  output logic          syncLow,
  output logic          syncAlt,
  output guardCfg_t     cfg,
  output logic [1:0]    rstStatus,
  output logic          warnFlag,
  output logic          stopActive,
  output logic          stopIs2,
  output logic          cntDone
);
  localparam int NUM_CMP = 3;
  localparam int CNT_W   = $clog2(HOLD_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HOLD_CYCLES - 1);

  logic [NUM_CMP-1:0] rawVec;
  logic [NUM_CMP-1:0] syncVec;
  logic [CNT_W-1:0]   holdCnt;

  assign rawVec = {belowAlt, belowLow, belowRearm};

  for (genvar i = 0; i < NUM_CMP; i++) begin : g_sync
    guard_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rstN (coldRstN),
      .din  (rawVec[i]),
      .dout (syncVec[i])
    );
  end

  assign syncRearm = syncVec[0];
  assign syncLow   = syncVec[1];
  assign syncAlt   = syncVec[2];

  // configuration bits
  always_ff @(posedge clk or negedge coldRstN) begin
    if (!coldRstN)             cfg <= CFG_DEFAULT;
    else if (strobes.porEvent) cfg <= CFG_DEFAULT;
    else if (cfgWrEn)          cfg <= guardCfg_t'(cfgWrData);
  end

  // reset cause record: only the latest event
  always_ff @(posedge clk or negedge coldRstN) begin
    if (!coldRstN)             rstStatus <= 2'b11;
    else if (strobes.porEvent) rstStatus <= 2'b11;
    else if (strobes.lvdEvent) rstStatus <= 2'b01;
  end

  // sticky warning, set wins over clear
  always_ff @(posedge clk or negedge coldRstN) begin
    if (!coldRstN)             warnFlag <= 1'b0;
    else if (strobes.porEvent) warnFlag <= 1'b0;
    else if (strobes.warnSet)  warnFlag <= 1'b1;
    else if (warnClr)          warnFlag <= 1'b0;
  end

  // stop mode grant with stop2 demotion
  always_ff @(posedge clk or negedge coldRstN) begin
    if (!coldRstN) begin
      stopActive <= 1'b0;
      stopIs2    <= 1'b0;
    end else if (strobes.porEvent || strobes.lvdEvent) begin
      stopActive <= 1'b0;
      stopIs2    <= 1'b0;
    end else if (strobes.stopEnter) begin
      stopActive <= 1'b1;
      stopIs2    <= stopKind & ~(cfg.detEn & cfg.stopDetEn);
    end else if (strobes.stopExit) begin
      stopActive <= 1'b0;
      stopIs2    <= 1'b0;
    end
  end

  // release qualification counter
  always_ff @(posedge clk or negedge coldRstN) begin
    if (!coldRstN)               holdCnt <= '0;
    else if (!strobes.cntStep)   holdCnt <= '0;
    else if (holdCnt != CNT_LAST) holdCnt <= holdCnt + 1'b1;
  end

  assign cntDone = (holdCnt == CNT_LAST);
endmodule

// File: rtl/guard_control.sv
module guard_control
  import guard_pkg::*;
(
  input  logic          clk,
  input  logic          coldRstN,
  input  logic          syncRearm,
  input  logic          syncLow,
  input  logic          syncAlt,
  input  guardCfg_t     cfg,
  input  logic          stopActive,
  input  logic          cntDone,
  input  logic          stopReq,
  input  logic          wakeReq,
  output guardStrobes_t strobes,
  output logic          sysRst,
  output logic          lvdActive
);
  guardState_e state, stateNext;
  logic selBelow;

  assign selBelow  = cfg.altSel ? syncAlt : syncLow;
  assign lvdActive = cfg.detEn & (~stopActive | cfg.stopDetEn);

  always_comb begin
    strobes   = '0;
    stateNext = state;
    unique case (state)
      ST_RUN: begin
        if (syncRearm) begin
          strobes.porEvent = 1'b1;
          stateNext        = ST_POR_HOLD;
        end else if (lvdActive && selBelow && cfg.rstEn) begin
          strobes.lvdEvent = 1'b1;
          stateNext        = ST_LVD_HOLD;
        end else begin
          strobes.warnSet = lvdActive & selBelow;
          if (stopActive) strobes.stopExit  = wakeReq;
          else            strobes.stopEnter = stopReq;
        end
      end
      ST_POR_HOLD: begin
        if (syncRearm) begin
          strobes.porEvent = 1'b1;
        end else if (!syncLow) begin
          strobes.cntStep = 1'b1;
          if (cntDone) stateNext = ST_RUN;
        end
      end
      ST_LVD_HOLD: begin
        if (syncRearm) begin
          strobes.porEvent = 1'b1;
          stateNext        = ST_POR_HOLD;
        end else if (!selBelow) begin
          strobes.cntStep = 1'b1;
          if (cntDone) stateNext = ST_RUN;
        end
      end
      default: stateNext = ST_POR_HOLD;
    endcase
  end

  always_ff @(posedge clk or negedge coldRstN) begin
    if (!coldRstN) state <= ST_POR_HOLD;
    else           state <= stateNext;
  end

  assign sysRst = (state != ST_RUN);
endmodule

// File: rtl/supply_guard.sv
module supply_guard
  import guard_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int HOLD_CYCLES = 8
) (
  input  logic       clk,
  input  logic       coldRstN,
  input  logic       belowRearm,
  input  logic       belowLow,
  input  logic       belowAlt,
  input  logic       cfgWrEn,
  input  logic [3:0] cfgWrData,
  input  logic       warnClr,
  input  logic       stopReq,
  input  logic       stopKind,
  input  logic       wakeReq,
  output logic       sysRst,
  output logic [1:0] rstStatus,
  output logic [3:0] cfgBits,
  output logic       warnFlag,
  output logic       lvdActive,
  output logic       stopActive,
  output logic       stopIs2
);
  guardStrobes_t strobes;
  guardCfg_t     cfg;
  logic syncRearm, syncLow, syncAlt, cntDone;

  guard_datapath #(.SYNC_STAGES(SYNC_STAGES), .HOLD_CYCLES(HOLD_CYCLES)) u_dp (
    .clk        (clk),
    .coldRstN   (coldRstN),
    .belowRearm (belowRearm),
    .belowLow   (belowLow),
    .belowAlt   (belowAlt),
    .cfgWrEn    (cfgWrEn),
    .cfgWrData  (cfgWrData),
    .warnClr    (warnClr),
    .stopKind   (stopKind),
    .strobes    (strobes),
    .syncRearm  (syncRearm),
    .syncLow    (syncLow),
    .syncAlt    (syncAlt),
    .cfg        (cfg),
    .rstStatus  (rstStatus),
    .warnFlag   (warnFlag),
    .stopActive (stopActive),
    .stopIs2    (stopIs2),
    .cntDone    (cntDone)
  );

  guard_control u_ctl (
    .clk        (clk),
    .coldRstN   (coldRstN),
    .syncRearm  (syncRearm),
    .syncLow    (syncLow),
    .syncAlt    (syncAlt),
    .cfg        (cfg),
    .stopActive (stopActive),
    .cntDone    (cntDone),
    .stopReq    (stopReq),
    .wakeReq    (wakeReq),
    .strobes    (strobes),
    .sysRst     (sysRst),
    .lvdActive  (lvdActive)
  );

  assign cfgBits = cfg;
endmodule

// File: rtl/guard_checker.sv
module guard_checker (
  input logic       clk,
  input logic       coldRstN,
  input logic       sysRst,
  input logic [1:0] rstStatus,
  input logic [3:0] cfgBits,
  input logic       warnFlag,
  input logic       stopActive,
  input logic       stopIs2,
  input logic       syncRearm
);
  assert_por_restores_R2: assert property (@(posedge clk) disable iff (!coldRstN)
    syncRearm |=> (sysRst && rstStatus == 2'b11 && cfgBits == 4'b0101));

  assert_lvd_cause_R4: assert property (@(posedge clk) disable iff (!coldRstN)
    ($rose(sysRst) && !$past(syncRearm)) |-> (rstStatus == 2'b01));

  assert_disabled_no_reset_R7: assert property (@(posedge clk) disable iff (!coldRstN)
    (!sysRst && !cfgBits[0] && !syncRearm) |=> !sysRst);

  assert_warn_only_no_reset_R8: assert property (@(posedge clk) disable iff (!coldRstN)
    $rose(warnFlag) |-> (!$past(cfgBits[2]) && !sysRst));

  assert_stop2_demoted_R10: assert property (@(posedge clk) disable iff (!coldRstN)
    $rose(stopActive) |-> !(stopIs2 && $past(cfgBits[0] && cfgBits[1])));

  assert_reset_leaves_stop_R11: assert property (@(posedge clk) disable iff (!coldRstN)
    sysRst |-> !stopActive);
endmodule

bind supply_guard guard_checker u_chk (
  .clk        (clk),
  .coldRstN   (coldRstN),
  .sysRst     (sysRst),
  .rstStatus  (rstStatus),
  .cfgBits    (cfgBits),
  .warnFlag   (warnFlag),
  .stopActive (stopActive),
  .stopIs2    (stopIs2),
  .syncRearm  (syncRearm)
);

// File: tb/tb_supply_guard.sv
module tb_supply_guard;
  localparam int HOLD = 8;

  logic clk = 1'b0;
  logic coldRstN = 1'b0;
  logic belowRearm = 1'b0, belowLow = 1'b0, belowAlt = 1'b0;
  logic cfgWrEn = 1'b0;
  logic [3:0] cfgWrData = 4'h0;
  logic warnClr = 1'b0, stopReq = 1'b0, stopKind = 1'b0, wakeReq = 1'b0;
  logic sysRst, warnFlag, lvdActive, stopActive, stopIs2;
  logic [1:0] rstStatus;
  logic [3:0] cfgBits;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #5 clk = ~clk;

  supply_guard #(.SYNC_STAGES(2), .HOLD_CYCLES(HOLD)) dut (
    .clk(clk), .coldRstN(coldRstN), .belowRearm(belowRearm), .belowLow(belowLow),
    .belowAlt(belowAlt), .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData), .warnClr(warnClr),
    .stopReq(stopReq), .stopKind(stopKind), .wakeReq(wakeReq), .sysRst(sysRst),
    .rstStatus(rstStatus), .cfgBits(cfgBits), .warnFlag(warnFlag), .lvdActive(lvdActive),
    .stopActive(stopActive), .stopIs2(stopIs2)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input string what, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic writeCfg(input logic [3:0] v);
    cfgWrEn = 1'b1; cfgWrData = v;
    tick(1);
    cfgWrEn = 1'b0;
  endtask

  task automatic t_cold();
    tick(3);
    chk("R1", "sysRst", sysRst, 1);
    chk("R1", "rstStatus", rstStatus, 3);
    chk("R1", "cfgBits", cfgBits, 5);
    chk("R1", "warnFlag", warnFlag, 0);
    chk("R1", "stopActive", stopActive, 0);
    coldRstN = 1'b1;
    tick(HOLD + 1);
    chk("R3", "sysRst before release", sysRst, 1);
    tick(1);
    chk("R3", "sysRst released", sysRst, 0);
  endtask

  task automatic t_lvd();
    writeCfg(4'b0111);
    belowLow = 1'b1;
    tick(2);
    chk("R4", "sysRst before sync", sysRst, 0);
    tick(1);
    chk("R4", "sysRst asserted", sysRst, 1);
    chk("R4", "rstStatus", rstStatus, 1);
    chk("R4", "cfg kept", cfgBits, 7);
    belowLow = 1'b0;
    tick(4);
    belowLow = 1'b1;
    tick(1);
    belowLow = 1'b0;
    tick(HOLD + 1);
    chk("R6", "bounce restarts count", sysRst, 1);
    tick(1);
    chk("R6", "released after count", sysRst, 0);
    writeCfg(4'b0101);
  endtask

  task automatic t_por();
    writeCfg(4'b1011);
    belowRearm = 1'b1; belowLow = 1'b1;
    tick(2);
    chk("R2", "sysRst before sync", sysRst, 0);
    tick(1);
    chk("R2", "sysRst asserted", sysRst, 1);
    chk("R2", "rstStatus", rstStatus, 3);
    chk("R2", "cfg defaults", cfgBits, 5);
    belowRearm = 1'b0;
    tick(HOLD + 4);
    chk("R3", "held while below low", sysRst, 1);
    belowLow = 1'b0;
    tick(HOLD + 1);
    chk("R3", "sysRst before release", sysRst, 1);
    tick(1);
    chk("R3", "sysRst released", sysRst, 0);
  endtask

  task automatic t_thresh();
    writeCfg(4'b1101);
    belowLow = 1'b1;
    tick(6);
    chk("R5", "unselected low ignored", sysRst, 0);
    belowAlt = 1'b1;
    tick(3);
    chk("R5", "alt asserts reset", sysRst, 1);
    belowAlt = 1'b0;
    tick(HOLD + 1);
    chk("R5", "alt hold", sysRst, 1);
    tick(1);
    chk("R5", "released on alt despite low", sysRst, 0);
    belowLow = 1'b0;
    tick(3);
    writeCfg(4'b0101);
  endtask

  task automatic t_disabled();
    writeCfg(4'b0100);
    chk("R7", "lvdActive", lvdActive, 0);
    belowLow = 1'b1;
    tick(6);
    chk("R7", "no reset", sysRst, 0);
    chk("R7", "no warning", warnFlag, 0);
    belowLow = 1'b0;
    tick(3);
    writeCfg(4'b0101);
  endtask

  task automatic t_warn();
    writeCfg(4'b0001);
    belowLow = 1'b1;
    tick(2);
    chk("R8", "warn before sync", warnFlag, 0);
    tick(1);
    chk("R8", "warn set", warnFlag, 1);
    chk("R8", "no reset", sysRst, 0);
    belowLow = 1'b0;
    tick(4);
    chk("R8", "warn sticky", warnFlag, 1);
    warnClr = 1'b1;
    tick(1);
    warnClr = 1'b0;
    chk("R8", "warn cleared", warnFlag, 0);
    writeCfg(4'b0101);
  endtask

  task automatic t_stop();
    stopReq = 1'b1; stopKind = 1'b1;
    tick(1);
    stopReq = 1'b0;
    chk("R11", "stop entered", stopActive, 1);
    chk("R10", "stop2 granted", stopIs2, 1);
    chk("R9", "detection off in stop", lvdActive, 0);
    belowLow = 1'b1;
    tick(6);
    chk("R9", "low ignored in stop", sysRst, 0);
    belowLow = 1'b0;
    tick(3);
    wakeReq = 1'b1;
    tick(1);
    wakeReq = 1'b0;
    chk("R11", "woken", stopActive, 0);
    chk("R9", "detection back on", lvdActive, 1);
    stopKind = 1'b0; stopReq = 1'b1;
    tick(1);
    stopReq = 1'b0;
    chk("R10", "stop3 request", stopIs2, 0);
    wakeReq = 1'b1;
    tick(1);
    wakeReq = 1'b0;
  endtask

  task automatic t_demote();
    writeCfg(4'b0111);
    stopReq = 1'b1; stopKind = 1'b1;
    tick(1);
    stopReq = 1'b0;
    chk("R10", "stop2 demoted", stopIs2, 0);
    chk("R10", "stop active", stopActive, 1);
    chk("R9", "detection kept in stop", lvdActive, 1);
    belowLow = 1'b1;
    tick(3);
    chk("R9", "reset in stop", sysRst, 1);
    chk("R11", "reset leaves stop", stopActive, 0);
    stopReq = 1'b1;
    tick(1);
    stopReq = 1'b0;
    chk("R11", "no stop in reset", stopActive, 0);
    belowLow = 1'b0;
    tick(HOLD + 2);
    chk("R6", "released", sysRst, 0);
    writeCfg(4'b0101);
  endtask

  initial begin
    t_cold();
    t_lvd();
    t_por();
    t_thresh();
    t_disabled();
    t_warn();
    t_stop();
    t_demote();
    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end
endmodule